// File: doc/BRIEF.md
# Fractional Nanosecond Time-Base Accumulator

This block is a free-running time-of-day counter. On every clock it adds a programmable increment to a wide fixed-point accumulator that counts nanoseconds, with 28 fraction bits. Nudging the increment up or down from its nominal value changes the rate of the time base in fine steps, so the time base can be steered against an outside reference. With the default widths the accumulator is 72 bits. It holds 44 integer bits, so whole nanoseconds wrap after 2^44 ns, which is about 4.9 hours.

Software sees the accumulator as three words: a low word, a middle time word and an 8-bit top word. It also sees a 32-bit increment word. Every word can be read and written through a plain select/strobe register port. To set the time, software first writes an increment of zero, which stops the counter. It then loads the three words and writes the increment back. Reading the low word captures the two upper words, so three reads in a row give one coherent value.

Capture logic elsewhere on the chip uses three live outputs: a 32-bit whole-nanosecond stamp, the full 44-bit nanosecond count, and the middle word for interval compares. The register port has no handshake. A strobe is taken in the cycle it is high, and read data is valid in the cycle after the read strobe.

Top module: `nco_timebase`

## Requirements
- R1: After reset the accumulator is zero and the increment is 0x8000_0000, which is 8.0 ns per clock in 4.28 format.
- R2: On every clock without a time-word write, the accumulator becomes its old value plus the zero-extended increment, modulo 2^72. Carries cross all three words in the same cycle.
- R3: While the increment is zero and no word is written, the accumulator holds its value.
- R4: reg_sel selects a word. Code 0 is the low word (accumulator bits 31:0). Code 1 is the time word (bits 63:32). Code 2 is the top word (bits 71:64, read in rdata bits 7:0 with the upper bits zero). Code 3 is the increment. A write takes effect at the clock edge where reg_wr is high. reg_rdata is valid one cycle after reg_rd is high.
- R5: Writes win over accumulation. In a cycle that writes code 0, 1 or 2, the written word takes reg_wdata, the other two words hold, and no increment is added. A write of code 3 does not stop that cycle's add. The add in that cycle uses the old increment, and the new increment applies from the next clock.
- R6: Reading code 0 returns the current low word and latches the time word and the top word. Reading code 1 or code 2 returns these latched copies, which are zero after reset.
- R7: ts_ns equals accumulator bits 59:28. Its upper 28 bits are time-word bits 27:0 and its lower 4 bits are low-word bits 31:28.
- R8: now_ns equals accumulator bits 71:28, a 44-bit whole-nanosecond count that wraps to zero after 2^44 ns.
- R9: coarse_time always shows the live time word, accumulator bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the word chosen by reg_sel |
| reg_rd | input | 1 | Read strobe for the word chosen by reg_sel |
| reg_sel | input | 2 | Word select: 0 low, 1 time, 2 top, 3 increment |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| ts_ns | output | 32 | Whole-nanosecond stamp for capture logic |
| now_ns | output | 44 | Full whole-nanosecond count |
| coarse_time | output | 32 | Live time word for interval compares |

## Verification
The assertions assume that reg_wr and reg_rd are never high in the same cycle and that reg_sel is stable while a strobe is high. The stimulus tasks raise only one strobe at a time and hold it for exactly one clock. The add and hold properties treat a cycle as write-free only when no time word is strobed, so the bench sets every start value while the increment is zero. It then runs a known number of clocks before it freezes the counter again. Start points sit just below carries out of the low word and the time word, and just below the 72-bit wrap.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // word select codes seen at the register port
  typedef enum logic [1:0] {
    WSEL_LOW = 2'd0,
    WSEL_MID = 2'd1,
    WSEL_TOP = 2'd2,
    WSEL_INC = 2'd3
  } wsel_e;
endpackage

// File: rtl/nco_accum.sv
module nco_accum
  import nco_pkg::*;
#(
  parameter int LO_W    = 32,
  parameter int MID_W   = 32,
  parameter int TOP_W   = 8,
  parameter int INC_W   = 32,
  parameter int REG_W   = 32,
  parameter logic [INC_W-1:0] INC_NOM = 32'h8000_0000,
  localparam int ACC_W  = LO_W + MID_W + TOP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  wsel_e            sel,
  input  logic [REG_W-1:0] wdata,
  output logic [ACC_W-1:0] acc,
  output logic [INC_W-1:0] inc
);
  localparam int MID_LSB = LO_W;
  localparam int TOP_LSB = LO_W + MID_W;

  logic             word_wr;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] acc_nxt;

  assign word_wr = wr && (sel != WSEL_INC);
  // single wide adder: carries ripple through every word in one cycle
  assign sum     = acc + ACC_W'(inc);

  always_comb begin
    acc_nxt = sum;
    if (word_wr) begin
      acc_nxt = acc;
      unique case (sel)
        WSEL_LOW: acc_nxt[LO_W-1:0]        = wdata[LO_W-1:0];
        WSEL_MID: acc_nxt[MID_LSB +: MID_W] = wdata[MID_W-1:0];
        WSEL_TOP: acc_nxt[TOP_LSB +: TOP_W] = wdata[TOP_W-1:0];
        default:  acc_nxt = acc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      inc <= INC_NOM;
    end else begin
      acc <= acc_nxt;
      if (wr && sel == WSEL_INC) inc <= wdata[INC_W-1:0];
    end
  end
endmodule

// File: rtl/nco_regif.sv
module nco_regif
  import nco_pkg::*;
#(
  parameter int LO_W   = 32,
  parameter int MID_W  = 32,
  parameter int TOP_W  = 8,
  parameter int INC_W  = 32,
  parameter int REG_W  = 32,
  localparam int ACC_W = LO_W + MID_W + TOP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  wsel_e            sel,
  input  logic [ACC_W-1:0] acc,
  input  logic [INC_W-1:0] inc,
  output logic [REG_W-1:0] rdata,
  output logic [MID_W-1:0] snap_mid
);
  logic [TOP_W-1:0] snap_top;
  logic [REG_W-1:0] rmux;

  always_comb begin
    unique case (sel)
      WSEL_LOW: rmux = REG_W'(acc[LO_W-1:0]);
      WSEL_MID: rmux = REG_W'(snap_mid);
      WSEL_TOP: rmux = REG_W'(snap_top);
      default:  rmux = REG_W'(inc);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      snap_mid <= '0;
      snap_top <= '0;
    end else if (rd) begin
      rdata <= rmux;
      if (sel == WSEL_LOW) begin
        snap_mid <= acc[LO_W +: MID_W];
        snap_top <= acc[LO_W+MID_W +: TOP_W];
      end
    end
  end
endmodule

// File: rtl/nco_tap.sv
module nco_tap #(
  parameter int LO_W   = 32,
  parameter int MID_W  = 32,
  parameter int TOP_W  = 8,
  parameter int FRAC_W = 28,
  parameter int TS_W   = 32,
  localparam int ACC_W = LO_W + MID_W + TOP_W,
  localparam int INT_W = ACC_W - FRAC_W
) (
  input  logic [ACC_W-1:0] acc,
  output logic [TS_W-1:0]  ts_ns,
  output logic [INT_W-1:0] now_ns,
  output logic [MID_W-1:0] coarse
);
  assign ts_ns  = acc[FRAC_W +: TS_W];
  assign now_ns = acc[ACC_W-1:FRAC_W];
  assign coarse = acc[LO_W +: MID_W];
endmodule

// File: rtl/nco_timebase.sv
module nco_timebase
  import nco_pkg::*;
#(
  parameter int LO_W    = 32,
  parameter int MID_W   = 32,
  parameter int TOP_W   = 8,
  parameter int INC_W   = 32,
  parameter int FRAC_W  = 28,
  parameter int TS_W    = 32,
  parameter int REG_W   = 32,
  parameter logic [INC_W-1:0] INC_NOM = 32'h8000_0000,
  localparam int ACC_W  = LO_W + MID_W + TOP_W,
  localparam int INT_W  = ACC_W - FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [TS_W-1:0]  ts_ns,
  output logic [INT_W-1:0] now_ns,
  output logic [MID_W-1:0] coarse_time
);
  wsel_e            sel;
  logic [ACC_W-1:0] acc_q;
  logic [INC_W-1:0] inc_q;
  logic [MID_W-1:0] snap_mid;

  assign sel = wsel_e'(reg_sel);

  nco_accum #(
    .LO_W(LO_W), .MID_W(MID_W), .TOP_W(TOP_W),
    .INC_W(INC_W), .REG_W(REG_W), .INC_NOM(INC_NOM)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(sel),
    .wdata(reg_wdata), .acc(acc_q), .inc(inc_q)
  );

  nco_regif #(
    .LO_W(LO_W), .MID_W(MID_W), .TOP_W(TOP_W),
    .INC_W(INC_W), .REG_W(REG_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .sel(sel),
    .acc(acc_q), .inc(inc_q), .rdata(reg_rdata), .snap_mid(snap_mid)
  );

  nco_tap #(
    .LO_W(LO_W), .MID_W(MID_W), .TOP_W(TOP_W),
    .FRAC_W(FRAC_W), .TS_W(TS_W)
  ) u_tap (
    .acc(acc_q), .ts_ns(ts_ns), .now_ns(now_ns), .coarse(coarse_time)
  );
endmodule

// File: rtl/nco_timebase_chk.sv
module nco_timebase_chk #(
  parameter int LO_W   = 32,
  parameter int MID_W  = 32,
  parameter int TOP_W  = 8,
  parameter int INC_W  = 32,
  parameter int REG_W  = 32,
  localparam int ACC_W = LO_W + MID_W + TOP_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_sel,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [ACC_W-1:0] acc,
  input logic [INC_W-1:0] inc,
  input logic [MID_W-1:0] snap_mid
);
  logic wr_word;
  assign wr_word = reg_wr && (reg_sel != 2'd3);

  // R2
  add_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_word)) |-> acc == $past(acc) + ACC_W'($past(inc)));

  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(inc) == '0 && !$past(wr_word)) |-> $stable(acc));

  // R5
  low_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr) && $past(reg_sel) == 2'd0)
      |-> acc[LO_W-1:0] == $past(reg_wdata[LO_W-1:0]));

  // R6
  low_read_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_rd) && $past(reg_sel) == 2'd0)
      |-> (reg_rdata == REG_W'($past(acc[LO_W-1:0])) && snap_mid == $past(acc[LO_W +: MID_W])));

  // R4
  inc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_rd) && $past(reg_sel) == 2'd3)
      |-> reg_rdata == REG_W'($past(inc)));

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

bind nco_timebase nco_timebase_chk #(
  .LO_W(LO_W), .MID_W(MID_W), .TOP_W(TOP_W), .INC_W(INC_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .acc(acc_q), .inc(inc_q), .snap_mid(snap_mid)
);

// File: tb/sim_nco_timebase.sv
module sim_nco_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] ts_ns;
  logic [43:0] now_ns;
  logic [31:0] coarse_time;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  nco_timebase u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ts_ns(ts_ns), .now_ns(now_ns), .coarse_time(coarse_time)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one strobe, held for exactly one clock edge
  task automatic wr_word(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_word(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic load(input logic [71:0] v);
    wr_word(2'd2, {24'h0, v[71:64]});
    wr_word(2'd1, v[63:32]);
    wr_word(2'd0, v[31:0]);
  endtask

  task automatic check_state(input string req, input logic [71:0] m);
    logic [31:0] r;
    check({req, " ts_ns"},  64'(ts_ns),       64'(m[59:28]));  // R7
    check({req, " now_ns"}, 64'(now_ns),      64'(m[71:28]));  // R8
    check({req, " coarse"}, 64'(coarse_time), 64'(m[63:32]));  // R9
    rd_word(2'd0, r); check({req, " low"},  64'(r), 64'(m[31:0]));
    rd_word(2'd1, r); check({req, " time"}, 64'(r), 64'(m[63:32]));
    rd_word(2'd2, r); check({req, " top"},  64'(r), 64'(m[71:64]));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [71:0] m;
    logic [71:0] starts [4];
    logic [31:0] incs [6];
    int          runs [3];
    starts[0] = 72'h0;
    starts[1] = {8'h00, 32'h0000_0000, 32'hFFFF_FFF0};
    starts[2] = {8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    starts[3] = {8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFF8};
    incs[0] = 32'h8000_0000; incs[1] = 32'h8000_0001; incs[2] = 32'h7FFF_FFFF;
    incs[3] = 32'hFFFF_FFFF; incs[4] = 32'h1000_0000; incs[5] = 32'h0000_0001;
    runs[0] = 0; runs[1] = 3; runs[2] = 17;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: three nominal steps of 8 ns after reset
    repeat (3) @(negedge clk);
    check("R1 now_ns after 3 clocks", 64'(now_ns), 64'd24);
    check("R7 ts_ns after 3 clocks",  64'(ts_ns),  64'd24);
    // R6: latched copy is zero before any low-word read
    rd_word(2'd1, r); check("R6 time copy at reset", 64'(r), 64'd0);
    rd_word(2'd3, r); check("R1 nominal increment", 64'(r), 64'h8000_0000);

    // R3: zero increment freezes
    wr_word(2'd3, 32'h0);
    m[43:0] = now_ns;
    repeat (20) @(negedge clk);
    check("R3 frozen now_ns", 64'(now_ns), 64'(m[43:0]));
    rd_word(2'd3, r); check("R4 increment readback", 64'(r), 64'd0);

    // R4 R7 R8 R9: loaded words visible everywhere
    m = {8'hA5, 32'h1234_5678, 32'h9ABC_DEF0};
    load(m);
    check_state("R4 loaded", m);
    check("R7 ts_ns window", 64'(ts_ns), 64'h2345_6789);
    check("R8 now_ns value", 64'(now_ns), 64'hA5_1234_5678_9);

    // R2: sweep start points, increments and run lengths; adds = run + 1
    foreach (starts[i]) foreach (incs[j]) foreach (runs[k]) begin
      load(starts[i]);
      wr_word(2'd3, incs[j]);
      repeat (runs[k]) @(negedge clk);
      wr_word(2'd3, 32'h0);
      m = starts[i] + 72'(runs[k] + 1) * 72'(incs[j]);
      check_state($sformatf("R2 s%0d i%0d n%0d", i, j, runs[k]), m);
    end

    // R5: word write wins over the add; increment write does not stop it
    m = {8'h01, 32'h0000_0010, 32'h0000_0000};
    load(m);
    wr_word(2'd3, 32'h3000_0000);
    wr_word(2'd0, 32'hF000_0000);
    wr_word(2'd3, 32'h0);
    check_state("R5 write priority", {8'h01, 32'h0000_0010, 32'hF000_0000} + 72'h3000_0000);

    // R6: snapshot taken at the low read survives later carries
    m = {8'h07, 32'hFFFF_FFFF, 32'hFFFF_FF00};
    load(m);
    wr_word(2'd3, 32'h8000_0000);
    rd_word(2'd0, r); check("R6 low at snapshot", 64'(r), 64'(m[31:0]));
    repeat (10) @(negedge clk);
    rd_word(2'd1, r); check("R6 time copy held", 64'(r), 64'hFFFF_FFFF);
    rd_word(2'd2, r); check("R6 top copy held",  64'(r), 64'h07);
    wr_word(2'd3, 32'h0);
    check("R6 live top moved on", 64'(now_ns[43:36]), 64'h08);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule